// File: doc/BRIEF.md
# Pipelined Leading-One Bit Normalizer

This block left-justifies a word. The output is the input moved left until its highest set bit sits in the most significant position, with zeros filling in from the right. The block also reports how many places it moved the word. Several inputs can give the same output: every one-hot input becomes a single bit in the top position. A designer uses the block to bring words into a form that does not depend on shift, or as the normalization step after a mantissa add.

The shifter is a cascade of log2(WIDTH) stages. The first stage moves the word by WIDTH/2, and each later stage moves it by half as much as the stage before, down to a 1-bit stage. A stage looks only at the top bits of its own input, as many bits as its own shift amount. If all of them are zero, the stage shifts. Otherwise it passes the word through unchanged. The block has no separate priority encoder.

The parameter `PIPELINED` picks the stage variant. In the registered variant (`STG_REG`, the default), each stage ends in a register, so the result appears log2(WIDTH) cycles after the input. In the combinational variant (`STG_COMB`), the result appears in the same cycle. The block has no state machine. Its only sequential state is the per-stage valid, data and count registers. A synchronous reset clears every valid bit.

Top module: `bitnorm_top`

## Requirements
- R1: For a valid non-zero input, the output equals the input shifted left until bit WIDTH-1 is 1, with zeros entering at bit 0.
- R2: An all-zero input gives an all-zero output and a shift count of WIDTH-1, because every stage shifts.
- R3: Inputs that differ only by a left shift give the same output. For example, every one-hot input gives a 1 in bit WIDTH-1 and zeros elsewhere.
- R4: An input whose bit WIDTH-1 is already 1 passes through unchanged, with shift count 0.
- R5: `out_shift` is the number of places the word moved. Bit CW-1-k of `out_shift` is the decision of stage k (stage 0 shifts by WIDTH/2), so the leading-zero count reads MSB first, and bits 0..`out_shift`-1 of a non-zero output are zero.
- R6: With `PIPELINED=1`, `out_vld`, `out_dat` and `out_shift` for an input appear exactly log2(WIDTH) clock edges after that input is sampled. A cycle with `in_vld=0` produces a cycle with `out_vld=0` at the same latency.
- R7: A clock edge with `rst=1` clears the valid bit in every stage. `out_vld` is 0 during reset and stays 0 for items that were in flight at that edge.
- R8: `WIDTH` must be a power of two of at least 2. The default is 16, which gives 4 stages and a 4-bit shift count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_vld | input | 1 | Input word is valid |
| in_dat | input | WIDTH | Word to normalize |
| out_vld | output | 1 | Output word and count are valid |
| out_dat | output | WIDTH | Left-justified word |
| out_shift | output | CW = log2(WIDTH) | Total shift applied, MSB = first stage |

## Verification
With the default registered variant, every result is due exactly four clock edges after its input is sampled. The bench keeps a four-deep history of sampled inputs, shifted on each rising edge and cleared as invalid by a reset edge. On every falling edge it compares `out_vld`, `out_dat` and `out_shift` with a leading-zero count it computes from the oldest entry. Because the comparison happens mid-cycle against that exact delay, a result that arrives one edge early or late fails the check. Each mismatch is tagged with a requirement chosen by the class of the input: zero, MSB already set, one-hot, or general.

// File: rtl/bitnorm_pkg.sv
package bitnorm_pkg;

    // Stage implementation variant
    typedef enum logic {
        STG_COMB = 1'b0,
        STG_REG  = 1'b1
    } stg_mode_e;

    // Number of cascaded stages for a given width
    function automatic int unsigned stage_count(input int unsigned w);
        return $clog2(w);
    endfunction

endpackage

// File: rtl/bitnorm_stage.sv
module bitnorm_stage
    import bitnorm_pkg::*;
#(
    parameter int unsigned WIDTH = 16,
    parameter int unsigned CW    = 4,
    parameter int unsigned SHIFT = 8,
    parameter int unsigned CBIT  = 3,
    parameter stg_mode_e   MODE  = STG_REG
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             vld_i,
    input  logic [WIDTH-1:0] dat_i,
    input  logic [CW-1:0]    cnt_i,
    output logic             vld_o,
    output logic [WIDTH-1:0] dat_o,
    output logic [CW-1:0]    cnt_o
);
    logic             take;
    logic [WIDTH-1:0] dat_nxt;
    logic [CW-1:0]    cnt_nxt;

    // Local sense of the top SHIFT bits decides this stage on its own
    always_comb begin
        take    = ~|dat_i[WIDTH-1 -: SHIFT];
        dat_nxt = take ? (dat_i << SHIFT) : dat_i;
        cnt_nxt = cnt_i;
        cnt_nxt[CBIT] = take;
    end

    generate
        if (MODE == STG_REG) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst) begin
                    vld_o <= 1'b0;
                    dat_o <= '0;
                    cnt_o <= '0;
                end else begin
                    vld_o <= vld_i;
                    dat_o <= dat_nxt;
                    cnt_o <= cnt_nxt;
                end
            end

            // R6
            vld_fwd_chk: assert property (@(posedge clk) disable iff (rst)
                vld_i |=> vld_o);
            // R6
            bubble_fwd_chk: assert property (@(posedge clk) disable iff (rst)
                !vld_i |=> !vld_o);
            // R1
            stage_keep_chk: assert property (@(posedge clk) disable iff (rst)
                (vld_i && dat_i[WIDTH-1]) |=> (dat_o == $past(dat_i)));
        end else begin : g_comb
            always_comb begin
                vld_o = vld_i;
                dat_o = dat_nxt;
                cnt_o = cnt_nxt;
            end
        end
    endgenerate

endmodule

// File: rtl/bitnorm_top.sv
module bitnorm_top
    import bitnorm_pkg::*;
#(
    parameter int unsigned WIDTH     = 16,
    parameter bit          PIPELINED = 1'b1,
    localparam int unsigned CW       = $clog2(WIDTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_vld,
    input  logic [WIDTH-1:0] in_dat,
    output logic             out_vld,
    output logic [WIDTH-1:0] out_dat,
    output logic [CW-1:0]    out_shift
);
    localparam int unsigned STAGES = stage_count(WIDTH);
    localparam stg_mode_e   MODE   = PIPELINED ? STG_REG : STG_COMB;

    // R8
    initial begin
        width_pow2_chk: assert (WIDTH >= 2 && (WIDTH & (WIDTH - 1)) == 0);
    end

    logic             vch [STAGES+1];
    logic [WIDTH-1:0] dch [STAGES+1];
    logic [CW-1:0]    cch [STAGES+1];

    always_comb begin
        vch[0] = in_vld;
        dch[0] = in_dat;
        cch[0] = '0;
    end

    generate
        for (genvar k = 0; k < STAGES; k++) begin : g_stage
            bitnorm_stage #(
                .WIDTH (WIDTH),
                .CW    (CW),
                .SHIFT (1 << (STAGES - 1 - k)),
                .CBIT  (CW - 1 - k),
                .MODE  (MODE)
            ) u_stg (
                .clk   (clk),
                .rst   (rst),
                .vld_i (vch[k]),
                .dat_i (dch[k]),
                .cnt_i (cch[k]),
                .vld_o (vch[k+1]),
                .dat_o (dch[k+1]),
                .cnt_o (cch[k+1])
            );
        end
    endgenerate

    always_comb begin
        out_vld   = vch[STAGES];
        out_dat   = dch[STAGES];
        out_shift = cch[STAGES];
    end

    logic [WIDTH-1:0] low_mask;
    always_comb low_mask = (WIDTH'(1) << out_shift) - WIDTH'(1);

    // R1
    msb_set_chk: assert property (@(posedge clk) disable iff (rst)
        (out_vld && out_dat != '0) |-> out_dat[WIDTH-1]);
    // R2
    zero_cnt_chk: assert property (@(posedge clk) disable iff (rst)
        (out_vld && out_dat == '0) |-> (out_shift == CW'(WIDTH - 1)));
    // R5
    zero_fill_chk: assert property (@(posedge clk) disable iff (rst)
        (out_vld && out_dat != '0) |-> ((out_dat & low_mask) == '0));

endmodule

// File: tb/sim_bitnorm_top.sv
`timescale 1ns/1ps
module sim_bitnorm_top;
    localparam int W  = 16;
    localparam int ST = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_vld = 1'b0;
    logic [W-1:0] in_dat = '0;
    logic         out_vld;
    logic [W-1:0] out_dat;
    logic [ST-1:0] out_shift;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    bit started = 1'b0;

    logic         hv [ST];
    logic [W-1:0] hd [ST];

    always #5 clk = ~clk;

    bitnorm_top #(.WIDTH(W), .PIPELINED(1'b1)) u0 (
        .clk(clk), .rst(rst), .in_vld(in_vld), .in_dat(in_dat),
        .out_vld(out_vld), .out_dat(out_dat), .out_shift(out_shift)
    );

    initial begin
        for (int i = 0; i < ST; i++) begin
            hv[i] = 1'b0;
            hd[i] = '0;
        end
    end

    // History of sampled inputs: index ST-1 is due at the output now
    always @(posedge clk) begin
        started <= 1'b1;
        if (rst) begin
            for (int i = 0; i < ST; i++) begin
                hv[i] <= 1'b0;
                hd[i] <= '0;
            end
        end else begin
            for (int i = ST - 1; i > 0; i--) begin
                hv[i] <= hv[i-1];
                hd[i] <= hd[i-1];
            end
            hv[0] <= in_vld;
            hd[0] <= in_dat;
        end
    end

    function automatic int lead_zeros(input logic [W-1:0] x);
        int n = 0;
        if (x == '0) return W - 1;
        for (int i = W - 1; i >= 0; i--) begin
            if (x[i]) break;
            n++;
        end
        return n;
    endfunction

    function automatic string tag_of(input logic [W-1:0] x);
        if (x == '0) return "R2";
        if (x[W-1]) return "R4";
        if ((x & (x - 1)) == '0) return "R3";
        return "R1";
    endfunction

    always @(negedge clk) begin
        if (started && !done) begin
            checks++;
            if (out_vld !== hv[ST-1]) begin
                failures++;
                $display("FAIL R6 R7 out_vld actual=%0b expected=%0b", out_vld, hv[ST-1]);
            end
            if (hv[ST-1]) begin
                logic [W-1:0] ed;
                int lz;
                lz = lead_zeros(hd[ST-1]);
                ed = (hd[ST-1] == '0) ? '0 : (hd[ST-1] << lz);
                checks++;
                if (out_dat !== ed) begin
                    failures++;
                    $display("FAIL %s out_dat in=%h actual=%h expected=%h",
                             tag_of(hd[ST-1]), hd[ST-1], out_dat, ed);
                end
                checks++;
                if (out_shift !== ST'(lz)) begin
                    failures++;
                    $display("FAIL R5 out_shift in=%h actual=%0d expected=%0d",
                             hd[ST-1], out_shift, lz);
                end
            end
        end
    end

    task automatic drive(input logic v, input logic [W-1:0] d);
        @(negedge clk);
        in_vld = v;
        in_dat = d;
    endtask

    initial begin : stim
        logic [31:0] r;
        r = 32'h1234_5678;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // directed: zero, MSB set, all one-hot (R3), general (R1)
        drive(1'b1, 16'h0000);
        drive(1'b1, 16'h8000);
        drive(1'b1, 16'hFFFF);
        for (int k = 0; k < W; k++) drive(1'b1, W'(1) << k);
        drive(1'b1, 16'h0003);
        drive(1'b1, 16'h00A0);
        drive(1'b1, 16'h0635);
        drive(1'b0, 16'h0001);
        drive(1'b1, 16'h0001);
        drive(1'b0, 16'h0000);
        drive(1'b1, 16'h7FFF);
        // reset with items in flight (R7)
        drive(1'b1, 16'h0011);
        drive(1'b1, 16'h0022);
        @(negedge clk);
        rst = 1'b1;
        in_vld = 1'b1;
        in_dat = 16'h0044;
        @(negedge clk);
        rst = 1'b0;
        // pseudo-random words with a spread of leading zeros
        for (int n = 0; n < 600; n++) begin
            r = r ^ (r << 13);
            r = r ^ (r >> 17);
            r = r ^ (r << 5);
            drive(r[24] | r[25], r[15:0] >> r[19:16]);
        end
        drive(1'b0, '0);
        repeat (ST + 2) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : watchdog
        #(100000 * 10);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule